// File: doc/BRIEF.md
# Ethernet MAC Transmit Framer

This block turns one Ethernet frame per request into a serial NRZ bit stream, one bit for each pulse of a clock enable, for a line encoder that follows it. The host writes the frame's header and payload bytes (destination address, source address, length/type and data) into a transmit buffer. The block reads those bytes through a simple address/data port. Once a request is pending, the block waits for two things: the number of bytes already buffered must reach a selected start threshold, and the medium must be granted. It then sends the preamble and the start delimiter, followed by the buffered bytes. Short frames are padded with zeros, and a CRC-32 frame check sequence is appended unless the request suppresses it.

A request carries the frame length in bytes (FCS excluded), a two-bit start-threshold code and an FCS-inhibit flag. When the last bit has left, the block raises a single-cycle completion pulse. An over-long frame is cut to the legal maximum and flagged at completion.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset `tx_active` and `done` are 0, `ready` is 1 and `tx_bit` is 0.
- R2: `start` is accepted only while `ready` is 1. A `start` pulse during a transmission changes neither that frame nor anything afterwards, and no second frame follows.
- R3: A pending frame begins (`tx_active` rises on the clock after the condition holds) only when `grant` is 1 and `buf_count` is at least the threshold. `thr_sel` codes 0, 1, 2 and 3 select 5, 381, 1021 bytes and the whole frame. A threshold above the frame length is replaced by the frame length.
- R4: Each frame opens with 56 preamble bits alternating 1,0,1,0,… (first bit 1), then the delimiter bits 1,0,1,0,1,0,1,1 in sending order.
- R5: After the delimiter, buffer bytes from address 0 upward are sent, each least significant bit first. One bit is consumed for each `bit_en` pulse, and `tx_bit` does not change between pulses.
- R6: A frame shorter than 60 bytes is extended with zero bytes up to 60 bytes.
- R7: Unless inhibited, 32 FCS bits follow the payload and pad. The FCS is the CRC-32 (polynomial 0x04C11DB7, preset all ones, result complemented) over all payload and pad bytes, sent coefficient x^31 first.
- R8: When `no_fcs` was 1 at the request, the frame ends right after the payload and pad.
- R9: A `frame_len` above 1514 sends only the first 1514 bytes, and `trunc_err` is 1 together with `done`. Otherwise `trunc_err` stays 0.
- R10: `done` is a one-cycle pulse in the clock cycle after the edge that consumes the frame's last bit. `tx_active` is 0 in that cycle.
- R11: `rd_en` pulses once for each buffer byte taken, only while `tx_active` is 1. `rd_addr` rises by one after each pulse. The pulse count per frame equals the sent payload length.
- R12: Outside a transmission `tx_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-time enable; each pulse consumes one output bit |
| start | input | 1 | Frame request pulse |
| frame_len | input | 11 | Bytes from destination address to end of data |
| thr_sel | input | 2 | Start threshold code (0:5, 1:381, 2:1021, 3:whole frame) |
| no_fcs | input | 1 | Suppress FCS for this frame |
| grant | input | 1 | Medium access granted |
| buf_count | input | 11 | Bytes of the pending frame already in the buffer |
| rd_addr | output | 11 | Buffer byte address being read |
| rd_en | output | 1 | Byte at `rd_addr` taken this cycle |
| rd_data | input | 8 | Buffer byte at `rd_addr` (combinational) |
| tx_bit | output | 1 | Serial NRZ data |
| tx_active | output | 1 | Frame on the wire |
| ready | output | 1 | Idle, request can be accepted |
| done | output | 1 | Frame completion pulse |
| trunc_err | output | 1 | Frame was truncated (with `done`) |

## Verification
The first bit of the stream appears on `tx_bit` one clock after the start condition (request pending, grant, enough bytes). Each later bit appears one clock after the `bit_en` edge that consumed the previous one, and `done` follows one clock after the edge that takes the final bit. The bench therefore compares `tx_bit` against a queue of expected bits at every falling edge where `bit_en` and `tx_active` are high, so each bit is checked in the cycle before the edge that consumes it. The bench checks the start gate one rising edge after changing `grant` or `buf_count`. It checks the emptiness of the queue, the truncation flag and the byte-read count at the falling edge where `done` is high.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PRE,
    ST_SFD,
    ST_DATA,
    ST_FCS
  } tx_state_e;

  typedef enum logic [1:0] {
    NB_BUF,
    NB_PAD,
    NB_END
  } next_byte_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [7:0]  PRE_BYTE      = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;

  // one bit of the reflected CRC-32 recurrence
  function automatic logic [31:0] crc_step(logic [31:0] c, logic b);
    return (c >> 1) ^ ((c[0] ^ b) ? CRC_POLY_REFL : 32'h0);
  endfunction

endpackage

// File: rtl/eth_tx_gate.sv
module eth_tx_gate #(
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1514,
  parameter int THR_A   = 5,
  parameter int THR_B   = 381,
  parameter int THR_C   = 1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [LEN_W-1:0] req_len,
  input  logic [1:0]       req_thr,
  input  logic             req_nofcs,
  input  logic             armed,
  input  logic             grant,
  input  logic [LEN_W-1:0] buf_count,
  output logic [LEN_W-1:0] send_len,
  output logic             nofcs,
  output logic             trunc,
  output logic             go
);
  localparam logic [LEN_W-1:0] MAX_W = LEN_W'(MAX_LEN);
  localparam logic [LEN_W-1:0] TA_W  = LEN_W'(THR_A);
  localparam logic [LEN_W-1:0] TB_W  = LEN_W'(THR_B);
  localparam logic [LEN_W-1:0] TC_W  = LEN_W'(THR_C);

  logic [1:0] thr_q;

  function automatic logic [LEN_W-1:0] eff_threshold(logic [1:0] sel, logic [LEN_W-1:0] len);
    logic [LEN_W-1:0] t;
    case (sel)
      2'd0:    t = TA_W;
      2'd1:    t = TB_W;
      2'd2:    t = TC_W;
      default: t = len;
    endcase
    return (t < len) ? t : len;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      send_len <= '0;
      thr_q    <= '0;
      nofcs    <= 1'b0;
      trunc    <= 1'b0;
    end else if (capture) begin
      send_len <= (req_len > MAX_W) ? MAX_W : req_len;
      trunc    <= (req_len > MAX_W);
      thr_q    <= req_thr;
      nofcs    <= req_nofcs;
    end
  end

  assign go = armed && grant && (buf_count >= eff_threshold(thr_q, send_len));
endmodule

// File: rtl/eth_tx_shifter.sv
module eth_tx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         bit_en,
  output logic         ser_bit,
  output logic         last_bit
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (load) begin
      sh  <= load_val;
      cnt <= '0;
    end else if (bit_en) begin
      sh  <= sh >> 1;
      cnt <= cnt + 1'b1;
    end
  end

  assign ser_bit  = sh[0];
  assign last_bit = (cnt == LAST);
endmodule

// File: rtl/eth_tx_fcs.sv
module eth_tx_fcs
  import eth_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic upd,
  input  logic upd_bit,
  input  logic seal,
  input  logic shift,
  output logic fcs_bit
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      crc_q <= '1;
    else if (init)   crc_q <= '1;
    else if (seal)   crc_q <= ~crc_step(crc_q, upd_bit);
    else if (upd)    crc_q <= crc_step(crc_q, upd_bit);
    else if (shift)  crc_q <= crc_q >> 1;
  end

  assign fcs_bit = crc_q[0];
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int LEN_W     = 11,
  parameter int MAX_LEN   = 1514,
  parameter int MIN_LEN   = 60,
  parameter int PRE_BYTES = 7,
  parameter int THR_A     = 5,
  parameter int THR_B     = 381,
  parameter int THR_C     = 1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [1:0]       thr_sel,
  input  logic             no_fcs,
  input  logic             grant,
  input  logic [LEN_W-1:0] buf_count,
  output logic [LEN_W-1:0] rd_addr,
  output logic             rd_en,
  input  logic [7:0]       rd_data,
  output logic             tx_bit,
  output logic             tx_active,
  output logic             ready,
  output logic             done,
  output logic             trunc_err
);
  localparam int PW = $clog2(PRE_BYTES + 1);
  localparam logic [PW-1:0]    PRE_LAST = PW'(PRE_BYTES - 1);
  localparam logic [LEN_W-1:0] MIN_W    = LEN_W'(MIN_LEN);

  tx_state_e        state;
  logic [PW-1:0]    pre_cnt;
  logic [LEN_W-1:0] data_pos;
  logic [4:0]       fcs_cnt;

  logic [LEN_W-1:0] send_len;
  logic             nofcs, trunc, go;
  logic             ser_bit, last_bit, fcs_bit;

  // named internal events
  logic       capture, byte_end, payload_end, frame_end, sh_load;
  logic [7:0] sh_val;
  next_byte_e nb;

  function automatic next_byte_e classify(logic [LEN_W-1:0] pos, logic [LEN_W-1:0] len);
    if (pos < len)        return NB_BUF;
    else if (pos < MIN_W) return NB_PAD;
    else                  return NB_END;
  endfunction

  assign capture     = start && (state == ST_IDLE);
  assign tx_active   = (state == ST_PRE) || (state == ST_SFD) || (state == ST_DATA) || (state == ST_FCS);
  assign ready       = (state == ST_IDLE);
  assign byte_end    = bit_en && last_bit && ((state == ST_PRE) || (state == ST_SFD) || (state == ST_DATA));
  assign payload_end = byte_end && ((state == ST_SFD) || (state == ST_DATA));
  assign nb          = classify(data_pos, send_len);
  assign rd_addr     = data_pos;
  assign rd_en       = payload_end && (nb == NB_BUF);
  assign frame_end   = (byte_end && (state == ST_DATA) && (nb == NB_END) && nofcs)
                    || (bit_en && (state == ST_FCS) && (fcs_cnt == 5'd31));

  always_comb begin
    sh_load = 1'b0;
    sh_val  = 8'h00;
    if (go) begin
      sh_load = 1'b1;
      sh_val  = PRE_BYTE;
    end else if (byte_end && (state == ST_PRE)) begin
      sh_load = 1'b1;
      sh_val  = (pre_cnt == PRE_LAST) ? SFD_BYTE : PRE_BYTE;
    end else if (payload_end && (nb != NB_END)) begin
      sh_load = 1'b1;
      sh_val  = (nb == NB_BUF) ? rd_data : 8'h00;
    end
  end

  eth_tx_gate #(
    .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .THR_A(THR_A), .THR_B(THR_B), .THR_C(THR_C)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .capture(capture), .req_len(frame_len), .req_thr(thr_sel),
    .req_nofcs(no_fcs), .armed(state == ST_WAIT), .grant(grant), .buf_count(buf_count),
    .send_len(send_len), .nofcs(nofcs), .trunc(trunc), .go(go)
  );

  eth_tx_shifter #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val), .bit_en(bit_en),
    .ser_bit(ser_bit), .last_bit(last_bit)
  );

  eth_tx_fcs u_fcs (
    .clk(clk), .rst_n(rst_n), .init(go),
    .upd(bit_en && (state == ST_DATA)), .upd_bit(ser_bit),
    .seal(byte_end && (state == ST_DATA) && (nb == NB_END) && !nofcs),
    .shift(bit_en && (state == ST_FCS)), .fcs_bit(fcs_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pre_cnt  <= '0;
      data_pos <= '0;
      fcs_cnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (capture) state <= ST_WAIT;
        ST_WAIT: if (go) begin
          state    <= ST_PRE;
          pre_cnt  <= '0;
          data_pos <= '0;
        end
        ST_PRE: if (byte_end) begin
          if (pre_cnt == PRE_LAST) state <= ST_SFD;
          else                     pre_cnt <= pre_cnt + 1'b1;
        end
        ST_SFD: if (byte_end) begin
          state    <= ST_DATA;
          data_pos <= data_pos + 1'b1;
        end
        ST_DATA: if (byte_end) begin
          if (nb == NB_END) begin
            state   <= nofcs ? ST_IDLE : ST_FCS;
            fcs_cnt <= '0;
          end else begin
            data_pos <= data_pos + 1'b1;
          end
        end
        ST_FCS: if (bit_en) begin
          if (fcs_cnt == 5'd31) state <= ST_IDLE;
          else                  fcs_cnt <= fcs_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      trunc_err <= 1'b0;
    end else begin
      done      <= frame_end;
      trunc_err <= frame_end && trunc;
    end
  end

  assign tx_bit = (state == ST_FCS) ? fcs_bit : (tx_active && ser_bit);
endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             grant,
  input logic             go,
  input logic [LEN_W-1:0] rd_addr,
  input logic             rd_en,
  input logic             tx_bit,
  input logic             tx_active,
  input logic             done,
  input logic             trunc_err
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !tx_active);
  // R12
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n) !tx_active |-> !tx_bit);
  // R3
  start_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_active) |-> $past(grant));
  // R3
  go_begins_chk: assert property (@(posedge clk) disable iff (!rst_n) go |=> tx_active);
  // R5
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && $past(tx_active) && !$past(bit_en)) |-> $stable(tx_bit));
  // R11
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_addr == $past(rd_addr) + 1'b1));
  // R11
  rd_active_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> tx_active);
  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) trunc_err |-> done);
endmodule

bind eth_tx_framer eth_tx_framer_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .grant(grant), .go(go),
  .rd_addr(rd_addr), .rd_en(rd_en), .tx_bit(tx_bit), .tx_active(tx_active),
  .done(done), .trunc_err(trunc_err)
);

// File: tb/eth_tx_framer_test.sv
module eth_tx_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 11;
  localparam int WD_LIMIT = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_en = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] frame_len = '0;
  logic [1:0]    thr_sel = '0;
  logic          no_fcs = 1'b0;
  logic          grant = 1'b0;
  logic [LW-1:0] buf_count = '0;
  logic [LW-1:0] rd_addr;
  logic          rd_en;
  logic [7:0]    rd_data;
  logic          tx_bit, tx_active, ready, done, trunc_err;

  logic [7:0] mem [0:2047];
  assign rd_data = mem[rd_addr];

  bit exp_q[$];
  bit exp_err;
  int exp_reads;
  int reads;
  int frames_done = 0;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int en_mode = 0;
  bit wd_hit = 1'b0;

  eth_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start), .frame_len(frame_len),
    .thr_sel(thr_sel), .no_fcs(no_fcs), .grant(grant), .buf_count(buf_count),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data), .tx_bit(tx_bit),
    .tx_active(tx_active), .ready(ready), .done(done), .trunc_err(trunc_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bit-enable pattern and watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT && !wd_hit) begin
      wd_hit = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
    end
    #1;
    bit_en = (en_mode == 0) ? 1'b1 : ((cyc % 3) != 2);
  end

  // monitor: one expected bit per consumed bit, frame end checks
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en) reads++;
      if (bit_en && tx_active) begin
        if (exp_q.size() == 0) check(1'b0, "R4/R5/R6/R7/R8 extra bit", 1, 0);
        else begin
          bit e;
          e = exp_q.pop_front();
          check(tx_bit == e, "R4/R5/R6/R7 stream bit", int'(tx_bit), int'(e));
        end
      end
      if (done) begin
        check(exp_q.size() == 0, "R8 R7 frame length, bits left", exp_q.size(), 0);
        check(trunc_err == exp_err, "R9 trunc_err", int'(trunc_err), int'(exp_err));
        check(!tx_active && !tx_bit, "R10 R12 idle at done", int'(tx_active), 0);
        check(reads == exp_reads, "R11 byte reads", reads, exp_reads);
        frames_done++;
      end
    end
  end

  // bench CRC: MSB-first register, input bits taken LSB first
  function automatic logic [31:0] bench_crc(bit [7:0] bytes[$]);
    logic [31:0] r = 32'hFFFF_FFFF;
    foreach (bytes[k]) begin
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = r[31] ^ bytes[k][i];
        r = {r[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
      end
    end
    return ~r;
  endfunction

  // driver: fill buffer, push expected stream
  task automatic build_frame(int len, bit nf);
    bit [7:0] pl[$];
    int n;
    logic [31:0] f;
    n = (len > 1514) ? 1514 : len;
    for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 37 + len * 11 + 3) & 255);
    for (int i = 0; i < 56; i++) exp_q.push_back((i % 2) == 0);
    exp_q.push_back(1); exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(0);
    exp_q.push_back(1); exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(1);
    for (int i = 0; i < n; i++) pl.push_back(mem[i]);
    while (pl.size() < 60) pl.push_back(8'h00);
    foreach (pl[k]) for (int b = 0; b < 8; b++) exp_q.push_back(pl[k][b]);
    if (!nf) begin
      f = bench_crc(pl);
      for (int b = 31; b >= 0; b--) exp_q.push_back(f[b]);
    end
    exp_err = (len > 1514);
    exp_reads = n;
    reads = 0;
  endtask

  task automatic request(int len, int thr, bit nf);
    @(posedge clk); #2;
    frame_len = LW'(len); thr_sel = 2'(thr); no_fcs = nf; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_frames(int target);
    while (frames_done < target && !wd_hit) @(posedge clk);
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic simple_frame(int len, int thr, bit nf);
    int t;
    t = frames_done + 1;
    build_frame(len, nf);
    buf_count = LW'((len > 1514) ? 1514 : len);
    grant = 1'b1;
    request(len, thr, nf);
    wait_frames(t);
  endtask

  initial begin
    int t;
    idle_cycles(4);
    @(negedge clk);
    // R1
    check(!tx_active && !done && ready && !tx_bit && !trunc_err, "R1 reset state",
          int'({tx_active, done, ready, tx_bit}), 2);
    #2 rst_n = 1'b1;
    idle_cycles(2);

    // R6 R7 short frame padded, FCS on, continuous bit_en
    simple_frame(46, 0, 1'b0);
    // R5 R7 exact minimum, gapped bit_en
    en_mode = 1;
    simple_frame(60, 0, 1'b0);
    // R8 R6 inhibited FCS, padding to 60
    simple_frame(10, 3, 1'b1);
    // R6 empty payload
    simple_frame(0, 0, 1'b0);
    // R8 longer frame without FCS
    simple_frame(75, 0, 1'b1);

    // R3 threshold 381 on a 500 byte frame
    t = frames_done + 1;
    build_frame(500, 1'b0);
    grant = 1'b1; buf_count = '0;
    request(500, 1, 1'b0);
    idle_cycles(8); @(negedge clk);
    check(!tx_active, "R3 below threshold (0)", int'(tx_active), 0);
    buf_count = 11'd380;
    idle_cycles(4); @(negedge clk);
    check(!tx_active, "R3 below threshold (380)", int'(tx_active), 0);
    @(posedge clk); #2 buf_count = 11'd381;
    @(posedge clk); @(negedge clk);
    check(tx_active, "R3 start at threshold 381", int'(tx_active), 1);
    // R2 start during transmission is ignored
    @(posedge clk); #2 frame_len = 11'd9; no_fcs = 1'b1; start = 1'b1;
    @(posedge clk); #2 start = 1'b0;
    wait_frames(t);
    buf_count = 11'd2000;
    idle_cycles(20); @(negedge clk);
    check(!tx_active && ready, "R2 no frame after ignored start", int'(tx_active), 0);

    // R3 grant gating with threshold 5
    t = frames_done + 1;
    build_frame(100, 1'b0);
    grant = 1'b0; buf_count = 11'd100;
    request(100, 0, 1'b0);
    idle_cycles(10); @(negedge clk);
    check(!tx_active, "R3 held without grant", int'(tx_active), 0);
    @(posedge clk); #2 grant = 1'b1;
    @(posedge clk); @(negedge clk);
    check(tx_active, "R3 start on grant", int'(tx_active), 1);
    wait_frames(t);

    // R3 threshold 1021 above frame length 40 -> frame length used
    t = frames_done + 1;
    build_frame(40, 1'b0);
    grant = 1'b1; buf_count = 11'd39;
    request(40, 2, 1'b0);
    idle_cycles(6); @(negedge clk);
    check(!tx_active, "R3 clipped threshold not yet met", int'(tx_active), 0);
    @(posedge clk); #2 buf_count = 11'd40;
    @(posedge clk); @(negedge clk);
    check(tx_active, "R3 clipped threshold met", int'(tx_active), 1);
    wait_frames(t);

    // R3 whole-frame threshold
    t = frames_done + 1;
    build_frame(200, 1'b0);
    grant = 1'b1; buf_count = 11'd199;
    request(200, 3, 1'b0);
    idle_cycles(6); @(negedge clk);
    check(!tx_active, "R3 whole frame not buffered", int'(tx_active), 0);
    @(posedge clk); #2 buf_count = 11'd200;
    @(posedge clk); @(negedge clk);
    check(tx_active, "R3 whole frame buffered", int'(tx_active), 1);
    wait_frames(t);

    // R9 truncation of an over-long frame
    en_mode = 0;
    simple_frame(1600, 0, 1'b0);
    // R9 largest legal frame, no flag
    simple_frame(1514, 0, 1'b0);

    idle_cycles(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule